// File: doc/BRIEF.md
# Select-Encoded ALU With Shift

This block is a combinational arithmetic, logic and shift unit of parameterised width, built as a chain of identical one-bit slices. A four-bit select code picks the operation in two levels. The upper pair of bits picks a group: arithmetic, logic, shift right or shift left. The lower pair, together with the carry input for the arithmetic group, picks the operation inside that group. Each slice sees its own bits of the two operands and also the neighbouring bits of the first operand, so that both shift directions can be formed locally. Ripple carry links the slices.

The combinational result and carry-out appear within the same cycle that the operands are presented. An optional output register, enabled by a parameter, captures them on every rising clock edge. A consumer can read either the immediate outputs or the registered copy.

Top module: `sel_alu`

## Requirements
- R1: The group is decoded from sel[3:2]: 00 is arithmetic, 01 is logic, 10 is shift right and 11 is shift left.
- R2: In the arithmetic group the result is (a + m + cin) mod 2^N. The value m is chosen by sel[1:0]: 00 gives b, 01 gives the bitwise complement of b, 10 gives zero and 11 gives all ones.
- R3: In the arithmetic group, co is bit N of the full-width sum a + m + cin.
- R4: In the logic group, sel[1:0] picks the operation: 00 gives a AND b, 01 gives a OR b, 10 gives a XOR b and 11 gives NOT a.
- R5: For sel[3:2] = 10, result bit i equals a[i+1], and the top bit is 0.
- R6: For sel[3:2] = 11, result bit i equals a[i-1], and bit 0 is 0.
- R7: In the logic and shift groups, cin has no effect on result or co.
- R8: In both shift groups, sel[1:0] has no effect on the result.
- R9: co is 0 whenever sel[3:2] is not 00.
- R10: With REG_OUT set, f_q and co_q hold the result and co present at the previous rising clock edge. An active-low asynchronous reset clears both to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| a | input | N | First operand, also the shifted operand |
| b | input | N | Second operand |
| cin | input | 1 | Carry input, used only by the arithmetic group |
| sel | input | 4 | Operation select: group in [3:2], variant in [1:0] |
| f | output | N | Combinational result |
| co | output | 1 | Combinational carry-out |
| f_q | output | N | Registered result |
| co_q | output | 1 | Registered carry-out |

## Verification
The case hardest to reach from the ports is a carry that ripples through every slice into co. This happens when a is all ones and the selected operand plus cin is nonzero, or when complement-of-b subtraction meets equal operands. The stimulus therefore crosses every select code and both carry values with a set of edge operands: zero, all ones, the top bit alone, one, and the largest positive value. Random operands follow. The insensitivity rules are checked by presenting the same operands twice, once with the carry toggled and once with each low select code, and comparing the two port results directly.

// File: rtl/sel_alu_pkg.sv
package sel_alu_pkg;

  typedef enum logic [1:0] {
    GRP_ARITH = 2'b00,
    GRP_LOGIC = 2'b01,
    GRP_SHR   = 2'b10,
    GRP_SHL   = 2'b11
  } grp_e;

  typedef enum logic [1:0] {
    OPND_B    = 2'b00,
    OPND_NB   = 2'b01,
    OPND_ZERO = 2'b10,
    OPND_ONES = 2'b11
  } opnd_e;

  typedef enum logic [1:0] {
    LOP_AND = 2'b00,
    LOP_OR  = 2'b01,
    LOP_XOR = 2'b10,
    LOP_NOT = 2'b11
  } lop_e;

  typedef struct packed {
    logic carry;
    logic sum;
  } fa_t;

  function automatic grp_e decode_grp(input logic [3:0] s);
    return grp_e'(s[3:2]);
  endfunction

  function automatic logic pick_operand(input logic b_bit, input logic [1:0] s);
    logic r;
    case (opnd_e'(s))
      OPND_B:    r = b_bit;
      OPND_NB:   r = ~b_bit;
      OPND_ZERO: r = 1'b0;
      default:   r = 1'b1;
    endcase
    return r;
  endfunction

  function automatic logic logic_bit(input logic x, input logic y, input logic [1:0] s);
    logic r;
    case (lop_e'(s))
      LOP_AND: r = x & y;
      LOP_OR:  r = x | y;
      LOP_XOR: r = x ^ y;
      default: r = ~x;
    endcase
    return r;
  endfunction

  function automatic fa_t full_add(input logic x, input logic y, input logic c);
    fa_t r;
    r.sum   = x ^ y ^ c;
    r.carry = (x & y) | (x & c) | (y & c);
    return r;
  endfunction

endpackage

// File: rtl/alu_slice.sv
module alu_slice
  import sel_alu_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  input  logic       a_lo,
  input  logic       a_hi,
  input  logic       c_i,
  input  logic [3:0] sel,
  output logic       f_o,
  output logic       c_o
);

  grp_e grp;
  logic op_bit;
  fa_t  fa;
  logic arith_bit;
  logic lgc_bit;
  logic shr_bit;
  logic shl_bit;

  assign grp       = decode_grp(sel);
  assign op_bit    = pick_operand(b_i, sel[1:0]);
  assign fa        = full_add(a_i, op_bit, c_i);
  assign arith_bit = fa.sum;
  assign lgc_bit   = logic_bit(a_i, b_i, sel[1:0]);
  assign shr_bit   = a_hi;
  assign shl_bit   = a_lo;
  assign c_o       = fa.carry;

  always_comb begin
    case (grp)
      GRP_ARITH: f_o = arith_bit;
      GRP_LOGIC: f_o = lgc_bit;
      GRP_SHR:   f_o = shr_bit;
      default:   f_o = shl_bit;
    endcase
  end

endmodule

// File: rtl/alu_chain.sv
module alu_chain
  import sel_alu_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         cin,
  input  logic [3:0]   sel,
  output logic [N-1:0] f,
  output logic         co,
  output logic [N:0]   carry_vec,
  output logic         arith_sel
);

  localparam int LAST = N - 1;

  logic [N-1:0] a_lo_v;
  logic [N-1:0] a_hi_v;

  assign a_lo_v       = {a[LAST-1:0], 1'b0};
  assign a_hi_v       = {1'b0, a[LAST:1]};
  assign carry_vec[0] = cin;

  generate
    for (genvar i = 0; i < N; i++) begin : g_slice
      alu_slice u_slice (
        .a_i  (a[i]),
        .b_i  (b[i]),
        .a_lo (a_lo_v[i]),
        .a_hi (a_hi_v[i]),
        .c_i  (carry_vec[i]),
        .sel  (sel),
        .f_o  (f[i]),
        .c_o  (carry_vec[i+1])
      );
    end
  endgenerate

  assign arith_sel = (decode_grp(sel) == GRP_ARITH);
  assign co        = arith_sel ? carry_vec[N] : 1'b0;

endmodule

// File: rtl/alu_outreg.sv
module alu_outreg #(
  parameter int N       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] f_d,
  input  logic         co_d,
  output logic [N-1:0] f_q,
  output logic         co_q
);

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          f_q  <= '0;
          co_q <= 1'b0;
        end else begin
          f_q  <= f_d;
          co_q <= co_d;
        end
      end

      // R10
      reg_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (f_q == $past(f_d) && co_q == $past(co_d)));
    end else begin : g_pass
      assign f_q  = f_d;
      assign co_q = co_d;
    end
  endgenerate

endmodule

// File: rtl/sel_alu.sv
module sel_alu
  import sel_alu_pkg::*;
#(
  parameter int N       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         cin,
  input  logic [3:0]   sel,
  output logic [N-1:0] f,
  output logic         co,
  output logic [N-1:0] f_q,
  output logic         co_q
);

  localparam int W = N + 1;

  logic [N:0] carry_vec;
  logic       arith_sel;
  grp_e       grp_w;

  assign grp_w = decode_grp(sel);

  alu_chain #(.N(N)) u_chain (
    .a         (a),
    .b         (b),
    .cin       (cin),
    .sel       (sel),
    .f         (f),
    .co        (co),
    .carry_vec (carry_vec),
    .arith_sel (arith_sel)
  );

  alu_outreg #(.N(N), .REG_OUT(REG_OUT)) u_outreg (
    .clk   (clk),
    .rst_n (rst_n),
    .f_d   (f),
    .co_d  (co),
    .f_q   (f_q),
    .co_q  (co_q)
  );

  function automatic logic [N:0] arith_word(input logic [N-1:0] x, input logic [N-1:0] y,
                                            input logic [1:0] s, input logic c);
    logic [N-1:0] m;
    case (opnd_e'(s))
      OPND_B:    m = y;
      OPND_NB:   m = ~y;
      OPND_ZERO: m = '0;
      default:   m = '1;
    endcase
    return {1'b0, x} + {1'b0, m} + W'(c);
  endfunction

  function automatic logic [N-1:0] logic_word(input logic [N-1:0] x, input logic [N-1:0] y,
                                              input logic [1:0] s);
    logic [N-1:0] r;
    case (lop_e'(s))
      LOP_AND: r = x & y;
      LOP_OR:  r = x | y;
      LOP_XOR: r = x ^ y;
      default: r = ~x;
    endcase
    return r;
  endfunction

  // R2 R3
  arith_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_w == GRP_ARITH) |-> ({co, f} == arith_word(a, b, sel[1:0], cin)));

  // R3
  carry_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arith_sel |-> (co == carry_vec[N]));

  // R4
  logic_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_w == GRP_LOGIC) |-> (f == logic_word(a, b, sel[1:0])));

  // R5
  shr_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_w == GRP_SHR) |-> (f == {1'b0, a[N-1:1]}));

  // R6
  shl_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_w == GRP_SHL) |-> (f == {a[N-2:0], 1'b0}));

  // R9
  no_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_w != GRP_ARITH) |-> (co == 1'b0));

endmodule

// File: tb/sim_sel_alu.sv
module sim_sel_alu;

  localparam int N    = 8;
  localparam int MASK = (1 << N) - 1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] a;
  logic [N-1:0] b;
  logic         cin;
  logic [3:0]   sel;
  logic [N-1:0] f;
  logic         co;
  logic [N-1:0] f_q;
  logic         co_q;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  int exp_q[$];

  always #4 clk = ~clk;

  sel_alu #(.N(N), .REG_OUT(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .a(a), .b(b), .cin(cin), .sel(sel),
    .f(f), .co(co), .f_q(f_q), .co_q(co_q)
  );

  function automatic int ref_model(int av, int bv, int s, int c);
    int m;
    int g = (s >> 2) & 3;
    int lo = s & 3;
    case (g)
      0: begin
        case (lo)
          0: m = bv;
          1: m = (~bv) & MASK;
          2: m = 0;
          default: m = MASK;
        endcase
        return av + m + c;
      end
      1: begin
        case (lo)
          0: return av & bv;
          1: return av | bv;
          2: return av ^ bv;
          default: return (~av) & MASK;
        endcase
      end
      2: return av >> 1;
      default: return (av << 1) & MASK;
    endcase
  endfunction

  function automatic string tag_of(int s);
    case ((s >> 2) & 3)
      0: return "R1 R2 R3";
      1: return "R1 R4 R9";
      2: return "R1 R5 R9";
      default: return "R1 R6 R9";
    endcase
  endfunction

  task automatic check(string req, int got, int expv);
    checks++;
    if (got != expv) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, expv);
    end
  endtask

  task automatic drive(int av, int bv, int s, int c, output int res);
    int expv;
    @(negedge clk);
    a   = av[N-1:0];
    b   = bv[N-1:0];
    sel = s[3:0];
    cin = c[0];
    #2;
    res  = int'({co, f});
    expv = ref_model(av, bv, s, c);
    check(tag_of(s), res, expv);
    exp_q.push_back(expv);
    @(posedge clk);
    #1;
    check("R10", int'({co_q, f_q}), exp_q.pop_front());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int edges[5];
    int r0;
    int r1;
    edges = '{0, MASK, 1 << (N - 1), 1, MASK >> 1};
    rst_n = 1'b0;
    a = '0; b = '0; cin = 1'b0; sel = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R10 reset f_q", int'(f_q), 0);
    check("R10 reset co_q", int'(co_q), 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int s = 0; s < 16; s++)
      for (int c = 0; c < 2; c++)
        for (int i = 0; i < 5; i++)
          for (int j = 0; j < 5; j++)
            drive(edges[i], edges[j], s, c, r0);

    // R7: carry input ignored outside the arithmetic group
    for (int s = 4; s < 16; s++)
      for (int k = 0; k < 6; k++) begin
        int av = $urandom & MASK;
        int bv = $urandom & MASK;
        drive(av, bv, s, 0, r0);
        drive(av, bv, s, 1, r1);
        check("R7 cin ignored", r1, r0);
      end

    // R8: low select bits ignored in the shift groups
    for (int g = 2; g < 4; g++)
      for (int k = 0; k < 6; k++) begin
        int av = $urandom & MASK;
        int bv = $urandom & MASK;
        drive(av, bv, g * 4, 0, r0);
        for (int lo = 1; lo < 4; lo++) begin
          drive(av, bv, g * 4 + lo, lo & 1, r1);
          check("R8 low select ignored", r1, r0);
        end
      end

    for (int k = 0; k < 400; k++)
      drive($urandom & MASK, $urandom & MASK, $urandom & 15, $urandom & 1, r0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule